// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block holds the configuration registers of a display controller. Every register exists twice: a working copy that software writes over a simple register bus, and a live copy that the rest of the controller reads through a flat output vector. Some register groups also have a third, intermediate copy. The working copy can be frozen into that intermediate copy while software keeps editing the working copy for the following frame.

Registers are arranged in eight group slots. Slot 0 is the general group. Window `i` uses slot `1+i`. The cursor uses slot 7, so it is numbered as if it were window 6. Software commits a group by writing a control word.

- Bits [7:0] of the control word request activation of the eight slots.
- Bits [15:8] request the freeze step for the same slots. Each freeze bit sits eight places above its activation bit.

An activation request stays pending until it is carried out. It is carried out on the next cycle if the controller is stopped. If the controller is running, it waits for the next `frame_start` pulse. The controller counts as stopped when the live copy of the general group's mode field is zero.

A read-select register decides what register reads return: the working copy or the live copy. There is no data stream through the block, so the bus is a plain single-cycle register port with no back-pressure.

Top module: `shadow_reg_bank`

## Requirements
- R1: After reset, all working, frozen and live copies are zero, nothing is pending, `ctrl_stopped` is 1, and reads return working copies.
- R2: A group register write (address bit 5 = 0, bits [4:2] = slot, bits [1:0] = register) changes only the working copy. The live copy and `act_cfg` keep their values until that group is activated.
- R3: While stopped, an activation bit written to the control register (address 0x20, bits [7:0]) reads back as pending for one cycle. On the following clock edge the live copy takes the source value, and the pending bit clears.
- R4: While running, a pending activation holds for any number of cycles. It completes on the clock edge where `frame_start` is high, and the bit then reads zero.
- R5: For three-stage groups (windows by default), a freeze bit (control bits [15:8]) copies the working copy into the frozen copy at the write edge. Activation then moves the frozen copy, not the current working copy, into the live copy. Activation without a fresh freeze reuses the older frozen contents.
- R6: Slot 0 is general, slot `1+i` is window `i`, and slot 7 is the cursor. Several activation bits in one write latch independently. Bits for absent window slots are never pending, and registers of absent slots read zero.
- R7: Register 0x21 bit 0 selects the read source: 1 returns live copies, 0 returns working copies. The register reads back its own value.
- R8: The running/stopped state changes only when the general group is activated. Clearing the mode field (general register 0, bits [1:0]) and activating it while running stops the controller at the next frame pulse.
- R9: A working-copy write in the same cycle as that group's latch is not part of that latch. It is carried by the next activation.
- R10: Freeze bits read back in control bits [15:8] for exactly one cycle after they are written, then read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | RB+4 | Register address: bit 5 set selects control (0) or read-select (1); otherwise slot and register index |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| ctrl_stopped | output | 1 | High while the live mode field is zero |
| act_cfg | output | 8*2^RB*DW | All live copies, slot-major then register |

## Verification
A corrupted pending bit shows up in the control readback on the very next read. It also shows up as a live copy that changes one cycle early or never. A frozen copy that was wrongly refreshed appears as the newer working value in the live readback one cycle after activation. A mis-timed latch window makes a same-cycle write leak into the live copy, and the read immediately after the frame pulse shows it. The table drives each of these orderings and compares every readback at the first cycle where the change could be seen.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int SLOTS     = 8;
  localparam int SLOT_W    = 3;
  localparam int GEN_SLOT  = 0;
  localparam int WIN_BASE  = 1;
  localparam int CUR_SLOT  = 7;
  localparam int MAX_WIN   = CUR_SLOT - WIN_BASE;
  localparam int UPD_SHIFT = 8;

  // slots that carry storage
  function automatic logic [SLOTS-1:0] slot_present(int nwin);
    logic [SLOTS-1:0] m;
    m = '0;
    m[GEN_SLOT] = 1'b1;
    m[CUR_SLOT] = 1'b1;
    for (int i = 0; i < MAX_WIN; i++)
      if (i < nwin) m[WIN_BASE+i] = 1'b1;
    return m;
  endfunction

  // slots with the intermediate frozen copy
  function automatic logic [SLOTS-1:0] slot_triple(int nwin, bit tri_win, bit tri_cur);
    logic [SLOTS-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_WIN; i++)
      if (tri_win && i < nwin) m[WIN_BASE+i] = 1'b1;
    m[CUR_SLOT] = tri_cur;
    return m;
  endfunction
endpackage

// File: rtl/shadow_group.sv
module shadow_group #(
  parameter int DW     = 32,
  parameter int RB     = 2,
  parameter bit TRIPLE = 1'b0,
  localparam int NREG  = 1 << RB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RB-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  input  logic               arm_now,
  input  logic               latch_now,
  input  logic [RB-1:0]      rd_idx,
  output logic [DW-1:0]      rd_asm,
  output logic [DW-1:0]      rd_act,
  output logic [NREG*DW-1:0] act_out
);
  logic [DW-1:0] asm_q [NREG];
  logic [DW-1:0] act_q [NREG];
  logic [DW-1:0] src_w [NREG];
  logic [NREG*DW-1:0] src_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) asm_q[i] <= '0;
    end else if (wr_en) begin
      asm_q[wr_idx] <= wr_data;
    end
  end

  generate
    if (TRIPLE) begin : g_three
      logic [DW-1:0] arm_q [NREG];
      logic [NREG*DW-1:0] arm_flat;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < NREG; i++) arm_q[i] <= '0;
        end else if (arm_now) begin
          for (int i = 0; i < NREG; i++) arm_q[i] <= asm_q[i];
        end
      end
      for (genvar r = 0; r < NREG; r++) begin : g_src
        assign src_w[r] = arm_q[r];
        assign arm_flat[r*DW +: DW] = arm_q[r];
      end
      // R5: frozen copy moves only on a freeze request
      a_r5_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_now |=> $stable(arm_flat));
    end else begin : g_two
      for (genvar r = 0; r < NREG; r++) begin : g_src
        assign src_w[r] = asm_q[r];
      end
      // R5: two-stage groups never receive a freeze strobe
      a_r5_no_freeze_two: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_now);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) act_q[i] <= '0;
    end else if (latch_now) begin
      for (int i = 0; i < NREG; i++) act_q[i] <= src_w[i];
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_flat
    assign act_out[r*DW +: DW]  = act_q[r];
    assign src_flat[r*DW +: DW] = src_w[r];
  end

  assign rd_asm = asm_q[rd_idx];
  assign rd_act = act_q[rd_idx];

  // R2: live copy holds between latches
  a_r2_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_now |=> $stable(act_out));
  // R9: a latch takes the source as it stood before the edge
  a_r9_latch_old_src: assert property (@(posedge clk) disable iff (!rst_n)
    latch_now |=> act_out == $past(src_flat));
endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl
  import shadow_bank_pkg::*;
#(
  parameter logic [SLOTS-1:0] PRESENT = '1,
  parameter logic [SLOTS-1:0] TRIPLE  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [SLOTS-1:0] req_act,
  input  logic [SLOTS-1:0] req_upd,
  input  logic             stopped,
  input  logic             frame_start,
  output logic [SLOTS-1:0] pending,
  output logic [SLOTS-1:0] upd_seen,
  output logic [SLOTS-1:0] arm_now,
  output logic [SLOTS-1:0] fire
);
  logic [SLOTS-1:0] new_act;
  logic             open_win;

  assign open_win = stopped | frame_start;
  assign fire     = pending & {SLOTS{open_win}};
  assign new_act  = ctl_we ? (req_act & PRESENT) : '0;
  assign arm_now  = ctl_we ? (req_upd & PRESENT & TRIPLE) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= '0;
      upd_seen <= '0;
    end else begin
      pending  <= (pending & ~fire) | new_act;
      upd_seen <= ctl_we ? (req_upd & PRESENT) : '0;
    end
  end

  // R6: absent slots never hold a request
  a_r6_absent_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~PRESENT) == '0);
  // R4: no request is dropped while running between frames
  a_r4_hold_running: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && !frame_start) |=> ((pending & $past(pending)) == $past(pending)));
  // R3: while stopped and idle on the bus, requests drain in one edge
  a_r3_stopped_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !ctl_we) |=> pending == '0);
  // R10: freeze readback lasts one cycle
  a_r10_upd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> upd_seen == '0);
endmodule

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank
  import shadow_bank_pkg::*;
#(
  parameter int DW         = 32,
  parameter int RB         = 2,
  parameter int NWIN       = 3,
  parameter bit TRIPLE_WIN = 1'b1,
  parameter bit TRIPLE_CUR = 1'b0,
  parameter int MODE_W     = 2,
  localparam int NREG      = 1 << RB,
  localparam int AW        = RB + SLOT_W + 1,
  localparam int GW        = NREG * DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_we,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic                frame_start,
  output logic                ctrl_stopped,
  output logic [SLOTS*GW-1:0] act_cfg
);
  localparam logic [SLOTS-1:0] PRESENT  = slot_present(NWIN);
  localparam logic [SLOTS-1:0] TRIPLE_M = slot_triple(NWIN, TRIPLE_WIN, TRIPLE_CUR);

  logic              is_cmd;
  logic [SLOT_W-1:0] slot;
  logic [RB-1:0]     ridx;
  logic              ctl_we;
  logic              acc_we;
  logic              rd_live_q;

  logic [SLOTS-1:0]  pending, upd_seen, arm_now, fire;
  logic [GW-1:0]     grp_act [SLOTS];
  logic [DW-1:0]     rd_asm  [SLOTS];
  logic [DW-1:0]     rd_act  [SLOTS];

  assign is_cmd = bus_addr[AW-1];
  assign slot   = bus_addr[RB +: SLOT_W];
  assign ridx   = bus_addr[RB-1:0];
  assign ctl_we = bus_we && is_cmd && !bus_addr[0];
  assign acc_we = bus_we && is_cmd && bus_addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_live_q <= 1'b0;
    else if (acc_we) rd_live_q <= bus_wdata[0];
  end

  assign ctrl_stopped = (grp_act[GEN_SLOT][MODE_W-1:0] == '0);

  commit_ctrl #(.PRESENT(PRESENT), .TRIPLE(TRIPLE_M)) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .req_act    (bus_wdata[SLOTS-1:0]),
    .req_upd    (bus_wdata[UPD_SHIFT +: SLOTS]),
    .stopped    (ctrl_stopped),
    .frame_start(frame_start),
    .pending    (pending),
    .upd_seen   (upd_seen),
    .arm_now    (arm_now),
    .fire       (fire)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (PRESENT[g]) begin : g_on
      shadow_group #(.DW(DW), .RB(RB), .TRIPLE(TRIPLE_M[g])) u_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we && !is_cmd && (slot == SLOT_W'(g))),
        .wr_idx   (ridx),
        .wr_data  (bus_wdata),
        .arm_now  (arm_now[g]),
        .latch_now(fire[g]),
        .rd_idx   (ridx),
        .rd_asm   (rd_asm[g]),
        .rd_act   (rd_act[g]),
        .act_out  (grp_act[g])
      );
    end else begin : g_off
      assign grp_act[g] = '0;
      assign rd_asm[g]  = '0;
      assign rd_act[g]  = '0;
    end
    assign act_cfg[g*GW +: GW] = grp_act[g];
  end

  always_comb begin
    bus_rdata = '0;
    if (is_cmd) begin
      if (bus_addr[0]) bus_rdata[0] = rd_live_q;
      else             bus_rdata[2*SLOTS-1:0] = {upd_seen, pending};
    end else begin
      bus_rdata = rd_live_q ? rd_act[slot] : rd_asm[slot];
    end
  end

  // R8: run/stop changes only through a general-group latch
  a_r8_mode_via_general: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_stopped) |-> $past(fire[GEN_SLOT]));
  // R4: while running and off the frame pulse, no group latches
  a_r4_no_early_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_stopped && !frame_start) |-> fire == '0);
endmodule

// File: tb/shadow_reg_bank_test.sv
module shadow_reg_bank_test;
  localparam int DW   = 32;
  localparam int RB   = 2;
  localparam int NREG = 1 << RB;
  localparam int AW   = RB + 4;
  localparam int N    = 63;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [AW-1:0]        bus_addr = '0;
  logic                 bus_we = 1'b0;
  logic [DW-1:0]        bus_wdata = '0;
  logic [DW-1:0]        bus_rdata;
  logic                 frame_start = 1'b0;
  logic                 ctrl_stopped;
  logic [8*NREG*DW-1:0] act_cfg;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  shadow_reg_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_start(frame_start),
    .ctrl_stopped(ctrl_stopped), .act_cfg(act_cfg)
  );

  // op: 0 write, 1 read-compare, 2 idle, 3 frame pulse, 4 frame pulse with write, 5 check stopped
  // fields: {op, addr, wdata, expected, requirement}
  localparam logic [76:0] VEC [0:N-1] = '{
    {3'd0, 6'h1C, 32'hA5A5_0001, 32'h0, 4'd2},          // R2 cursor working write
    {3'd1, 6'h1C, 32'h0, 32'hA5A5_0001, 4'd2},          // R2 working readback
    {3'd0, 6'h21, 32'h1, 32'h0, 4'd7},                  // R7 select live
    {3'd1, 6'h1C, 32'h0, 32'h0, 4'd2},                  // R2 live untouched
    {3'd0, 6'h20, 32'h80, 32'h0, 4'd3},                 // R3 activate cursor
    {3'd1, 6'h20, 32'h0, 32'h80, 4'd3},                 // R3 pending visible
    {3'd1, 6'h1C, 32'h0, 32'hA5A5_0001, 4'd3},          // R3 latched
    {3'd1, 6'h20, 32'h0, 32'h0, 4'd3},                  // R3 cleared
    {3'd0, 6'h04, 32'h1111_1111, 32'h0, 4'd5},          // R5 window0 working
    {3'd0, 6'h20, 32'h200, 32'h0, 4'd10},               // R10 freeze window0
    {3'd1, 6'h20, 32'h0, 32'h200, 4'd10},               // R10 freeze seen
    {3'd1, 6'h20, 32'h0, 32'h0, 4'd10},                 // R10 freeze gone
    {3'd0, 6'h04, 32'h2222_2222, 32'h0, 4'd5},          // R5 newer working
    {3'd0, 6'h20, 32'h2, 32'h0, 4'd5},                  // R5 activate window0
    {3'd2, 6'h00, 32'h0, 32'h0, 4'd5},
    {3'd1, 6'h04, 32'h0, 32'h1111_1111, 4'd5},          // R5 frozen value live
    {3'd0, 6'h21, 32'h0, 32'h0, 4'd7},                  // R7 select working
    {3'd1, 6'h04, 32'h0, 32'h2222_2222, 4'd7},
    {3'd0, 6'h21, 32'h1, 32'h0, 4'd7},
    {3'd0, 6'h08, 32'h3333_0000, 32'h0, 4'd6},          // R6 window1
    {3'd0, 6'h1D, 32'h7777_0001, 32'h0, 4'd6},          // R6 cursor reg1
    {3'd0, 6'h20, 32'h400, 32'h0, 4'd6},                // R6 freeze window1
    {3'd0, 6'h20, 32'h94, 32'h0, 4'd6},                 // R6 window1+cursor+absent slot4
    {3'd1, 6'h20, 32'h0, 32'h84, 4'd6},                 // R6 absent bit dropped
    {3'd1, 6'h08, 32'h0, 32'h3333_0000, 4'd6},
    {3'd1, 6'h1D, 32'h0, 32'h7777_0001, 4'd6},
    {3'd0, 6'h10, 32'hFFFF_FFFF, 32'h0, 4'd6},          // R6 absent slot write
    {3'd1, 6'h10, 32'h0, 32'h0, 4'd6},
    {3'd0, 6'h00, 32'h1, 32'h0, 4'd8},                  // R8 mode run
    {3'd0, 6'h20, 32'h1, 32'h0, 4'd8},
    {3'd2, 6'h00, 32'h0, 32'h0, 4'd8},
    {3'd1, 6'h00, 32'h0, 32'h1, 4'd8},
    {3'd5, 6'h00, 32'h0, 32'h0, 4'd8},                  // R8 running
    {3'd0, 6'h1E, 32'h0BAD_0002, 32'h0, 4'd4},          // R4 cursor reg2
    {3'd0, 6'h20, 32'h80, 32'h0, 4'd4},
    {3'd2, 6'h00, 32'h0, 32'h0, 4'd4},
    {3'd2, 6'h00, 32'h0, 32'h0, 4'd4},
    {3'd1, 6'h20, 32'h0, 32'h80, 4'd4},                 // R4 still pending
    {3'd1, 6'h1E, 32'h0, 32'h0, 4'd4},
    {3'd3, 6'h00, 32'h0, 32'h0, 4'd4},
    {3'd1, 6'h1E, 32'h0, 32'h0BAD_0002, 4'd4},          // R4 latched on frame
    {3'd1, 6'h20, 32'h0, 32'h0, 4'd4},
    {3'd0, 6'h1F, 32'h1000_0000, 32'h0, 4'd9},          // R9 cursor reg3
    {3'd0, 6'h20, 32'h80, 32'h0, 4'd9},
    {3'd4, 6'h1F, 32'h2000_0000, 32'h0, 4'd9},          // R9 write on latch edge
    {3'd1, 6'h1F, 32'h0, 32'h1000_0000, 4'd9},
    {3'd0, 6'h21, 32'h0, 32'h0, 4'd9},
    {3'd1, 6'h1F, 32'h0, 32'h2000_0000, 4'd9},
    {3'd0, 6'h21, 32'h1, 32'h0, 4'd9},
    {3'd0, 6'h20, 32'h80, 32'h0, 4'd9},
    {3'd3, 6'h00, 32'h0, 32'h0, 4'd9},
    {3'd1, 6'h1F, 32'h0, 32'h2000_0000, 4'd9},          // R9 next commit
    {3'd0, 6'h00, 32'h0, 32'h0, 4'd8},                  // R8 stop request
    {3'd0, 6'h20, 32'h1, 32'h0, 4'd8},
    {3'd2, 6'h00, 32'h0, 32'h0, 4'd8},
    {3'd1, 6'h00, 32'h0, 32'h1, 4'd8},
    {3'd3, 6'h00, 32'h0, 32'h0, 4'd8},
    {3'd1, 6'h00, 32'h0, 32'h0, 4'd8},
    {3'd5, 6'h00, 32'h0, 32'h1, 4'd8},                  // R8 stopped
    {3'd0, 6'h20, 32'h2, 32'h0, 4'd5},                  // R5 no fresh freeze
    {3'd2, 6'h00, 32'h0, 32'h0, 4'd5},
    {3'd1, 6'h04, 32'h0, 32'h1111_1111, 4'd5},
    {3'd1, 6'h21, 32'h0, 32'h1, 4'd7}                   // R7 readback
  };

  task automatic check(input int req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd_check(input int req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    @(negedge clk);
    bus_we = 1'b0; frame_start = 1'b0; bus_addr = a;
    #1 check(req, bus_rdata, exp);
  endtask

  task automatic reset_checks();
    check(1, DW'(ctrl_stopped), 32'h1);                 // R1
    check(1, DW'(act_cfg == '0), 32'h1);                // R1
    rd_check(1, 6'h20, 32'h0);                          // R1 nothing pending
    rd_check(1, 6'h21, 32'h0);                          // R1 working reads
    rd_check(1, 6'h04, 32'h0);                          // R1 working zero
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reset_checks();
    for (int k = 0; k < N; k++) begin
      logic [2:0]    op;
      logic [AW-1:0] a;
      logic [DW-1:0] d, e;
      logic [3:0]    rq;
      {op, a, d, e, rq} = VEC[k];
      @(negedge clk);
      bus_we = 1'b0; frame_start = 1'b0;
      case (op)
        3'd0: begin bus_addr = a; bus_wdata = d; bus_we = 1'b1; end
        3'd1: begin bus_addr = a; #1 check(int'(rq), bus_rdata, e); end
        3'd3: frame_start = 1'b1;
        3'd4: begin frame_start = 1'b1; bus_addr = a; bus_wdata = d; bus_we = 1'b1; end
        3'd5: begin #1 check(int'(rq), DW'(ctrl_stopped), e); end
        default: ;
      endcase
    end
    @(negedge clk);
    bus_we = 1'b0; frame_start = 1'b0;
    // R3 live copy visible at the output vector: cursor slot 7, register 0
    check(3, act_cfg[(7*NREG)*DW +: DW], 32'hA5A5_0001);
    // R6 window1 slot 2 register 0 at the output vector
    check(6, act_cfg[(2*NREG)*DW +: DW], 32'h3333_0000);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    reset_checks();                                     // R1 after a mid-run reset
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule